// File: doc/BRIEF.md
# Light Measurement Window Interrupt

This block sits behind a light sensor's conversion path. It compares each 16-bit measurement result against a programmable window, formed by an inclusive lower bound and an inclusive upper bound. It raises an active-low interrupt after a programmable number of consecutive out-of-window results. The interrupt stays latched until the host reads the status register.

The host reaches the block through a small byte-wide register port with a write strobe, a read strobe and a 3-bit address. Each threshold is written in two byte accesses. The low byte is held in a shadow register and takes effect only when the high byte is written, so the comparator never uses a half-updated bound. The status register combines four things: the latched interrupt flag, a conversion-done flag, a sticky brownout flag that powers up set, and the code of the channel being converted.

Top module: `light_window_irq`

## Requirements
- R1: After reset the lower bound is 0x0000, the upper bound is 0xFFFF, the persistence field is 0, irq_no is high and the status register (address 5) reads 0x04 when chan_i is 00.
- R2: A write to address 1 (lower bound, low byte) or address 3 (upper bound, low byte) goes to a shadow register and does not change the bound in use or its readback. A write to address 2 (or 4) loads the whole bound at once, with the written byte as bits 15:8 and the shadow as bits 7:0. Reads of addresses 1 to 4 return the bytes of the bounds in use.
- R3: A valid result counts as out of window when it is less than or equal to the lower bound, or greater than or equal to the upper bound.
- R4: When the interrupt fires, status bit 0 becomes 1 and irq_no goes low in the cycle after the firing result. Both stay latched until they are cleared.
- R5: A read of the status register (reg_re_i with address 5) clears status bit 0 and releases irq_no at the end of that cycle. The read itself returns the flags as they were before the clear.
- R6: The persistence field (address 0, bits 1:0; codes 0,1,2,3 select 1,2,4,8) sets how many consecutive out-of-window valid results are needed. The interrupt fires on every out-of-window result whose run length is at least that number. An in-window valid result restarts the run. Cycles without a valid result leave the run unchanged.
- R7: If an interrupt fires in the same cycle as a status read, the flag and irq_no stay set.
- R8: Status bit 1 is set by conv_done_i and cleared by a status read. A done strobe in the same cycle as the read wins.
- R9: Status bit 2 is 1 after reset, is cleared by any write to address 5, and is never set again until the next reset.
- R10: Status bits 5:4 show chan_i live (00 none, 01 green, 10 red, 11 blue). Bits 7:6 and bit 3 read as zero.
- R11: Address 0 reads the persistence field in bits 1:0 with zeros above. Addresses 6 and 7 read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; a status read clears flags |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| smp_valid_i | input | 1 | Measurement result valid |
| smp_data_i | input | 16 | Measurement result |
| conv_done_i | input | 1 | Integration cycle done strobe |
| chan_i | input | 2 | Channel under conversion |
| irq_no | output | 1 | Latched interrupt, active low |

## Verification
The main collision is a firing out-of-window result that lands in the same cycle as a host status read that would clear the flag. The same kind of collision exists between the done strobe and the conversion-done clear. The bench provokes both on purpose by driving the strobe and the read in one cycle. It then checks the read data, which must show the old value, and it checks irq_no and a follow-up status read, which must show the flag still set. A lower-byte write followed by a result that only the new bound would trigger is also run, to confirm the shadow keeps the old bound in use until the high byte is written. A behavioural model compares irq_no on every cycle and the read data on every read.

// File: rtl/lwi_pkg.sv
package lwi_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PERS = 3'd0,
    A_LO_L = 3'd1,
    A_LO_H = 3'd2,
    A_HI_L = 3'd3,
    A_HI_H = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/lwi_thr.sv
module lwi_thr #(
  parameter int unsigned           BYTE_W  = 8,
  parameter logic [2*BYTE_W-1:0]   RST_VAL = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lo_we_i,
  input  logic                  hi_we_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  output logic [2*BYTE_W-1:0]   thr_o
);
  logic [BYTE_W-1:0]   shadow_q;
  logic [2*BYTE_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_VAL[BYTE_W-1:0];
      thr_q    <= RST_VAL;
    end else begin
      if (lo_we_i) shadow_q <= wdata_i;
      if (hi_we_i) thr_q    <= {wdata_i, shadow_q};
    end
  end

  assign thr_o = thr_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i && !hi_we_i |=> $stable(thr_q)); // R2
endmodule

// File: rtl/lwi_regs.sv
module lwi_regs
  import lwi_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PERS_W = 2,
  localparam int unsigned THR_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [THR_W-1:0]  lo_thr_o,
  output logic [THR_W-1:0]  hi_thr_o,
  output logic [PERS_W-1:0] pers_o,
  output logic [BYTE_W-1:0] cfg_rdata_o
);
  logic [THR_W-1:0]  thr [2];
  logic [PERS_W-1:0] pers_q;

  for (genvar g = 0; g < 2; g++) begin : g_thr
    localparam logic [ADDR_W-1:0] LA     = ADDR_W'(1 + 2 * g);
    localparam logic [THR_W-1:0]  RV     = (g == 0) ? '0 : '1;
    lwi_thr #(.BYTE_W(BYTE_W), .RST_VAL(RV)) u_thr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_we_i (we_i && addr_i == LA),
      .hi_we_i (we_i && addr_i == LA + ADDR_W'(1)),
      .wdata_i (wdata_i),
      .thr_o   (thr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pers_q <= '0;
    else if (we_i && addr_i == A_PERS) pers_q <= wdata_i[PERS_W-1:0];
  end

  assign lo_thr_o = thr[0];
  assign hi_thr_o = thr[1];
  assign pers_o   = pers_q;

  always_comb begin
    cfg_rdata_o = '0;
    case (addr_i)
      A_PERS: cfg_rdata_o[PERS_W-1:0] = pers_q;
      A_LO_L: cfg_rdata_o = thr[0][BYTE_W-1:0];
      A_LO_H: cfg_rdata_o = thr[0][THR_W-1:BYTE_W];
      A_HI_L: cfg_rdata_o = thr[1][BYTE_W-1:0];
      A_HI_H: cfg_rdata_o = thr[1][THR_W-1:BYTE_W];
      default: cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lwi_persist.sv
module lwi_persist #(
  parameter int unsigned THR_W  = 16,
  parameter int unsigned PERS_W = 2,
  localparam int unsigned MAX_NEED = 1 << ((1 << PERS_W) - 1),
  localparam int unsigned CNT_W    = $clog2(MAX_NEED + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [THR_W-1:0]  data_i,
  input  logic [THR_W-1:0]  lo_i,
  input  logic [THR_W-1:0]  hi_i,
  input  logic [PERS_W-1:0] sel_i,
  output logic              fire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, need;
  logic             out_win;

  assign out_win = (data_i <= lo_i) || (data_i >= hi_i);
  assign need    = CNT_W'(1) << sel_i;
  // saturate at the largest need so a later, longer setting still sees the run
  assign cnt_nx  = (cnt_q == CNT_W'(MAX_NEED)) ? cnt_q : cnt_q + CNT_W'(1);
  assign fire_o  = valid_i && out_win && (cnt_nx >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= out_win ? cnt_nx : '0;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_NEED)); // R6
  AST_RUN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !out_win |=> cnt_q == '0); // R6
  AST_IDLE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/lwi_status.sv
module lwi_status #(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            done_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [CH_W-1:0] chan_i,
  output logic            irq_o,
  output logic [7:0]      stat_o
);
  logic irq_q, conv_q, bout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      conv_q <= 1'b0;
      bout_q <= 1'b1;
    end else begin
      // set beats clear
      if (fire_i)    irq_q  <= 1'b1;
      else if (rd_i) irq_q  <= 1'b0;
      if (done_i)    conv_q <= 1'b1;
      else if (rd_i) conv_q <= 1'b0;
      if (wr_i)      bout_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign stat_o = {2'b00, chan_i, 1'b0, bout_q, conv_q, irq_q};

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> irq_q); // R7
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !fire_i |=> !irq_q); // R5
  AST_IRQ_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !rd_i |=> irq_q); // R4
  AST_CONV_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> conv_q); // R8
  AST_BOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(bout_q)); // R9
endmodule

// File: rtl/light_window_irq.sv
module light_window_irq
  import lwi_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PERS_W = 2,
  parameter int unsigned CH_W   = 2,
  localparam int unsigned THR_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              smp_valid_i,
  input  logic [THR_W-1:0]  smp_data_i,
  input  logic              conv_done_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              irq_no
);
  logic [THR_W-1:0]  lo_thr, hi_thr;
  logic [PERS_W-1:0] pers;
  logic [BYTE_W-1:0] cfg_rdata;
  logic [7:0]        stat;
  logic              fire, irq, stat_sel;

  assign stat_sel = (reg_addr_i == A_STAT);

  lwi_regs #(.BYTE_W(BYTE_W), .PERS_W(PERS_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .lo_thr_o    (lo_thr),
    .hi_thr_o    (hi_thr),
    .pers_o      (pers),
    .cfg_rdata_o (cfg_rdata)
  );

  lwi_persist #(.THR_W(THR_W), .PERS_W(PERS_W)) u_persist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .data_i  (smp_data_i),
    .lo_i    (lo_thr),
    .hi_i    (hi_thr),
    .sel_i   (pers),
    .fire_o  (fire)
  );

  lwi_status #(.CH_W(CH_W)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .done_i (conv_done_i),
    .rd_i   (reg_re_i && stat_sel),
    .wr_i   (reg_we_i && stat_sel),
    .chan_i (chan_i),
    .irq_o  (irq),
    .stat_o (stat)
  );

  assign reg_rdata_o = stat_sel ? BYTE_W'(stat) : cfg_rdata;
  assign irq_no      = ~irq;

  AST_PIN_FOLLOWS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !irq_no); // R4
endmodule

// File: tb/sim_light_window_irq.sv
`timescale 1ns/1ps
module sim_light_window_irq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = '0;
  logic        conv_done_i = 1'b0;
  logic [1:0]  chan_i = '0;
  logic        irq_no;

  int n_cmp = 0, n_bad = 0;

  // behavioural reference state
  int m_lo = 0, m_hi = 'hFFFF, m_sh_lo = 0, m_sh_hi = 'hFF, m_pers = 0, m_run = 0;
  bit m_irq = 0, m_conv = 0, m_bout = 1;

  always #4 clk_i = ~clk_i;

  light_window_irq u0 (.*);

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int a, input int ch);
    case (a)
      0: return m_pers;
      1: return m_lo & 'hFF;
      2: return (m_lo >> 8) & 'hFF;
      3: return m_hi & 'hFF;
      4: return (m_hi >> 8) & 'hFF;
      5: return (ch << 4) | (int'(m_bout) << 2) | (int'(m_conv) << 1) | int'(m_irq);
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit we, input bit re, input int a, input int wd,
                      input bit v, input int d, input bit dn, input int ch, input string tag);
    bit fire, out;
    reg_we_i = we; reg_re_i = re; reg_addr_i = 3'(a); reg_wdata_i = 8'(wd);
    smp_valid_i = v; smp_data_i = 16'(d); conv_done_i = dn; chan_i = 2'(ch);
    #2;
    if (re) cmp(tag, int'(reg_rdata_o), exp_rd(a, ch));
    out  = (d <= m_lo) || (d >= m_hi);
    fire = 0;
    if (v) begin
      m_run = out ? m_run + 1 : 0;
      fire  = out && (m_run >= (1 << m_pers));
    end
    if (fire) m_irq = 1; else if (re && a == 5) m_irq = 0;
    if (dn) m_conv = 1; else if (re && a == 5) m_conv = 0;
    if (we) case (a)
      0: m_pers = wd & 3;
      1: m_sh_lo = wd;
      2: m_lo = (wd << 8) | m_sh_lo;
      3: m_sh_hi = wd;
      4: m_hi = (wd << 8) | m_sh_hi;
      5: m_bout = 0;
      default: ;
    endcase
    @(posedge clk_i); #1;
    cmp(tag, int'(irq_no), int'(!m_irq));
  endtask

  task automatic wr(input int a, input int wd, input string tag);
    step(1, 0, a, wd, 0, 0, 0, 0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(0, 1, a, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic smp(input int d, input string tag);
    step(0, 0, 0, 0, 1, d, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lfsr;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cmp("R1", int'(irq_no), 1);
    for (int a = 0; a < 6; a++) rd(a, "R1");
    rd(6, "R11"); rd(7, "R11");

    // brownout clears on status write only
    rd(5, "R9");
    wr(5, 'hFF, "R9");
    rd(5, "R9");
    cmp("R9", int'(reg_rdata_o[2]), 0);

    // default window: 0 and FFFF are out (inclusive)
    smp('h0000, "R3"); cmp("R4", int'(irq_no), 0);
    smp('h8000, "R4"); cmp("R4", int'(irq_no), 0);
    rd(5, "R5"); cmp("R5", int'(irq_no), 1);
    smp('hFFFF, "R3"); rd(5, "R5");
    smp('h8000, "R3");

    // shadow: low byte alone changes nothing
    wr(1, 'h00, "R2"); wr(3, 'h00, "R2");
    rd(1, "R2"); rd(3, "R2");
    smp('h0050, "R2"); cmp("R2", int'(irq_no), 1);
    wr(2, 'h10, "R2"); wr(4, 'h20, "R2");
    for (int a = 1; a < 5; a++) rd(a, "R2");
    smp('h1000, "R3"); rd(5, "R3");
    smp('h2000, "R3"); rd(5, "R3");
    smp('h1001, "R3"); smp('h1FFF, "R3");
    cmp("R3", int'(irq_no), 1);

    // persistence 8: seven out, one in, then eight out
    wr(0, 'hFF, "R11"); rd(0, "R11");
    for (int i = 0; i < 7; i++) smp('h0100, "R6");
    cmp("R6", int'(irq_no), 1);
    smp('h1800, "R6");
    for (int i = 0; i < 7; i++) begin
      smp('h3000, "R6");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    end
    cmp("R6", int'(irq_no), 1);
    smp('h3000, "R6"); cmp("R6", int'(irq_no), 0);
    rd(5, "R6"); smp('h3000, "R6");
    for (int p = 0; p < 3; p++) begin
      wr(0, p, "R6"); rd(5, "R6");
      for (int i = 0; i < 5; i++) smp((i == 2) ? 'h1500 : 'h0001, "R6");
    end

    // collisions: fire or done in the cycle of a status read
    wr(0, 0, "R7"); rd(5, "R7");
    step(0, 1, 5, 0, 1, 'h0005, 0, 0, "R7");
    cmp("R7", int'(irq_no), 0);
    rd(5, "R7"); cmp("R7", int'(irq_no), 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, "R8");
    rd(5, "R8"); rd(5, "R8");
    step(0, 1, 5, 0, 0, 0, 1, 0, "R8");
    rd(5, "R8");

    // channel code and reserved bits
    for (int c = 0; c < 4; c++) step(0, 1, 5, 0, 0, 0, 0, c, "R10");

    // unmapped writes do nothing
    wr(6, 'hAA, "R11"); wr(7, 'h55, "R11");
    for (int a = 0; a < 8; a++) rd(a, "R11");

    // mixed traffic
    lfsr = 'hACE1;
    for (int i = 0; i < 600; i++) begin
      bit we, re, v, dn;
      int a;
      lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 'hFFFF;
      v  = lfsr[0] | lfsr[1];
      dn = lfsr[2] & lfsr[3];
      re = lfsr[4] & lfsr[5];
      we = !re && (lfsr[6] & lfsr[7] & lfsr[8]);
      a  = (lfsr >> 9) & 7;
      if (we && a == 5 && lfsr[12]) a = 0;
      step(we, re, a, (lfsr >> 3) & 'hFF, v, (lfsr * 7) & 'hFFFF, dn, (lfsr >> 13) & 3, "R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule